// File: doc/BRIEF.md
# Two-Phase Nonoverlapping Enable Generator

This block drives the timing of a latch-style processor core that has been rebuilt as flip-flop logic on a single master clock. It makes no derived clocks. A free-running counter, compared against thresholds, produces two registered phase enables, `phi1_o` and `phi2_o`. They alternate with a dead interval after each phase, so the two enables never overlap. Each phase also has a single-cycle start strobe and a single-cycle end strobe. The core's flip-flops qualify their enables with these strobes in place of latch transparency windows.

The block also replaces the keeper on one shared internal bus. Up to `N_DRV` sources each present a `BUS_W`-bit value, and each source has its own enable bit. When exactly one enable is set, a holder register on the master clock captures that source's value. When no enable is set, which includes every dead interval, the holder keeps presenting the last value that was driven. Two or more enables in the same cycle count as a fault: the holder keeps its value and a sticky flag is raised.

Top module: `phase_enable_gen`

## Requirements
- R1: `phi1_o` and `phi2_o` are never 1 in the same cycle.
- R2: With period P = 2*(PHASE_LEN+GAP_LEN), each period runs in this order:
  - `phi1_o` high for PHASE_LEN cycles;
  - both enables low for GAP_LEN cycles;
  - `phi2_o` high for PHASE_LEN cycles;
  - both enables low for GAP_LEN cycles.
- R3: While `rst_ni` is 0, all phase and strobe outputs are 0. The first rising clock edge after release starts the first `phi1_o` cycle.
- R4: `phi1_rise_o` and `phi2_rise_o` are 1 only in the first cycle of their phase.
- R5: `phi1_fall_o` and `phi2_fall_o` are 1 only in the last cycle of their phase. When PHASE_LEN=1, the rise strobe and the fall strobe of a phase are 1 in the same cycle.
- R6: Driver k's value sits at `bus_i[k*BUS_W +: BUS_W]`. When `drv_en_i` has only bit k set, `bus_o` shows that value from the next cycle on.
- R7: When `drv_en_i` is 0, `bus_o` keeps its value, whatever `bus_i` carries.
- R8: When more than one bit of `drv_en_i` is set:
  - `bus_o` keeps its value;
  - `contention_o` becomes 1 in the next cycle and stays 1 until reset;
  - later single-driver loads still work.
- R9: Reset clears `bus_o` and `contention_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drv_en_i | input | N_DRV | Per-driver enables for the shared bus |
| bus_i | input | N_DRV*BUS_W | Driver values; driver k in bits k*BUS_W +: BUS_W |
| phi1_o | output | 1 | Phase 1 enable |
| phi2_o | output | 1 | Phase 2 enable |
| phi1_rise_o | output | 1 | First cycle of phase 1 |
| phi1_fall_o | output | 1 | Last cycle of phase 1 |
| phi2_rise_o | output | 1 | First cycle of phase 2 |
| phi2_fall_o | output | 1 | Last cycle of phase 2 |
| bus_o | output | BUS_W | Held bus value |
| contention_o | output | 1 | Sticky: more than one driver was enabled at once |

## Verification
Two functions can land in the same cycle: a phase's start strobe and its end strobe, which coincide when PHASE_LEN is 1. To provoke this, a second instance is built with PHASE_LEN=1 and GAP_LEN=1. Every cycle over several periods, both instances' outputs are compared against a schedule computed from the cycle count since reset. On the short instance, both strobes must be high in the single phase cycle, and the gap cycles must stay low.

// File: rtl/phase_pkg.sv
package phase_pkg;
  typedef enum logic [1:0] {
    SEG_PHI1 = 2'd0,
    SEG_GAP1 = 2'd1,
    SEG_PHI2 = 2'd2,
    SEG_GAP2 = 2'd3
  } seg_e;

  function automatic seg_e seg_of(input int pos, input int plen, input int glen);
    if (pos < plen)                 return SEG_PHI1;
    else if (pos < plen + glen)     return SEG_GAP1;
    else if (pos < 2 * plen + glen) return SEG_PHI2;
    else                            return SEG_GAP2;
  endfunction
endpackage

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int PERIOD = 12,
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (cnt_q == CW'(PERIOD - 1)) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/phase_decode.sv
module phase_decode
  import phase_pkg::*;
#(
  parameter int PHASE_LEN = 4,
  parameter int GAP_LEN   = 2,
  localparam int PERIOD   = 2 * (PHASE_LEN + GAP_LEN),
  localparam int CW       = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  output logic          phi1_o,
  output logic          phi2_o,
  output logic          phi1_rise_o,
  output logic          phi1_fall_o,
  output logic          phi2_rise_o,
  output logic          phi2_fall_o
);
  seg_e seg;
  int   pos;

  always_comb begin
    pos = int'(cnt_i);
    seg = seg_of(pos, PHASE_LEN, GAP_LEN);
  end

  // outputs registered from the current count: glitch-free enables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phi1_o      <= 1'b0;
      phi2_o      <= 1'b0;
      phi1_rise_o <= 1'b0;
      phi1_fall_o <= 1'b0;
      phi2_rise_o <= 1'b0;
      phi2_fall_o <= 1'b0;
    end else begin
      phi1_o      <= (seg == SEG_PHI1);
      phi2_o      <= (seg == SEG_PHI2);
      phi1_rise_o <= (pos == 0);
      phi1_fall_o <= (pos == PHASE_LEN - 1);
      phi2_rise_o <= (pos == PHASE_LEN + GAP_LEN);
      phi2_fall_o <= (pos == 2 * PHASE_LEN + GAP_LEN - 1);
    end
  end

  p_exclusive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phi1_o && phi2_o));
  p_gap_before_phi2_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phi2_o) |-> !$past(phi1_o));
  p_gap_before_phi1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phi1_o) |-> !$past(phi2_o));
  p_rise1_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phi1_rise_o |-> (phi1_o && !$past(phi1_o)));
  p_rise2_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phi2_rise_o |-> (phi2_o && !$past(phi2_o)));
  p_fall1_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phi1_fall_o |=> !phi1_o);
  p_fall2_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phi2_fall_o |=> !phi2_o);
endmodule

// File: rtl/bus_holder.sv
module bus_holder #(
  parameter int BUS_W = 8,
  parameter int N_DRV = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_DRV-1:0]       drv_en_i,
  input  logic [N_DRV*BUS_W-1:0] bus_i,
  output logic [BUS_W-1:0]       bus_o,
  output logic                   contention_o
);
  logic [BUS_W-1:0] sel_val;
  logic             any_en;
  logic             multi_en;

  always_comb begin
    sel_val = '0;
    for (int k = 0; k < N_DRV; k++)
      if (drv_en_i[k]) sel_val |= bus_i[k*BUS_W +: BUS_W];
  end

  assign any_en   = |drv_en_i;
  assign multi_en = |(drv_en_i & (drv_en_i - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_o        <= '0;
      contention_o <= 1'b0;
    end else begin
      if (any_en && !multi_en) bus_o <= sel_val;
      if (multi_en)            contention_o <= 1'b1;
    end
  end

  p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_i == '0) |=> $stable(bus_o));
  p_hold_multi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(drv_en_i) > 1) |=> ($stable(bus_o) && contention_o));
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    contention_o |=> contention_o);
  p_load_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(drv_en_i) == 1) |=> (bus_o == $past(sel_val)));
endmodule

// File: rtl/phase_enable_gen.sv
module phase_enable_gen #(
  parameter int PHASE_LEN = 4,
  parameter int GAP_LEN   = 2,
  parameter int BUS_W     = 8,
  parameter int N_DRV     = 3,
  localparam int PERIOD   = 2 * (PHASE_LEN + GAP_LEN),
  localparam int CW       = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_DRV-1:0]       drv_en_i,
  input  logic [N_DRV*BUS_W-1:0] bus_i,
  output logic                   phi1_o,
  output logic                   phi2_o,
  output logic                   phi1_rise_o,
  output logic                   phi1_fall_o,
  output logic                   phi2_rise_o,
  output logic                   phi2_fall_o,
  output logic [BUS_W-1:0]       bus_o,
  output logic                   contention_o
);
  logic [CW-1:0] cnt;

  phase_counter #(.PERIOD(PERIOD)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt)
  );

  phase_decode #(.PHASE_LEN(PHASE_LEN), .GAP_LEN(GAP_LEN)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt),
    .phi1_o     (phi1_o),
    .phi2_o     (phi2_o),
    .phi1_rise_o(phi1_rise_o),
    .phi1_fall_o(phi1_fall_o),
    .phi2_rise_o(phi2_rise_o),
    .phi2_fall_o(phi2_fall_o)
  );

  bus_holder #(.BUS_W(BUS_W), .N_DRV(N_DRV)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .drv_en_i    (drv_en_i),
    .bus_i       (bus_i),
    .bus_o       (bus_o),
    .contention_o(contention_o)
  );
endmodule

// File: tb/phase_enable_gen_tb.sv
module phase_enable_gen_tb;
  localparam int PL = 4, GL = 2, W = 8, ND = 3;
  localparam int PS = 1, GS = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ND-1:0]   en = '0;
  logic [ND*W-1:0] bus = '0;

  logic phi1, phi2, r1, f1, r2, f2, cont;
  logic [W-1:0] bo;
  logic s_phi1, s_phi2, s_r1, s_f1, s_r2, s_f2, s_cont;
  logic [W-1:0] s_bo;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phase_enable_gen #(.PHASE_LEN(PL), .GAP_LEN(GL), .BUS_W(W), .N_DRV(ND)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .drv_en_i(en), .bus_i(bus),
    .phi1_o(phi1), .phi2_o(phi2), .phi1_rise_o(r1), .phi1_fall_o(f1),
    .phi2_rise_o(r2), .phi2_fall_o(f2), .bus_o(bo), .contention_o(cont));

  phase_enable_gen #(.PHASE_LEN(PS), .GAP_LEN(GS), .BUS_W(W), .N_DRV(ND)) u_dut_short (
    .clk_i(clk), .rst_ni(rst_n), .drv_en_i('0), .bus_i('0),
    .phi1_o(s_phi1), .phi2_o(s_phi2), .phi1_rise_o(s_r1), .phi1_fall_o(s_f1),
    .phi2_rise_o(s_r2), .phi2_fall_o(s_f2), .bus_o(s_bo), .contention_o(s_cont));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // expected {phi1,phi2,r1,f1,r2,f2} for cycle k>=1 after reset release
  function automatic logic [5:0] sched(input int k, input int pl, input int gl);
    int m = (k - 1) % (2 * (pl + gl));
    return {m < pl, (m >= pl + gl) && (m < 2 * pl + gl), m == 0, m == pl - 1,
            m == pl + gl, m == 2 * pl + gl - 1};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R3 phases in reset", {26'd0, phi1, phi2, r1, f1, r2, f2}, 32'd0);
    chk("R3 short phases in reset", {26'd0, s_phi1, s_phi2, s_r1, s_f1, s_r2, s_f2}, 32'd0);
    chk("R9 bus in reset", {24'd0, bo}, 32'd0);
    chk("R9 contention in reset", {31'd0, cont}, 32'd0);
  endtask

  task automatic t_phases();
    rst_n = 1'b1;
    for (int k = 1; k <= 3 * 2 * (PL + GL); k++) begin
      @(negedge clk);
      chk($sformatf("R2 R4 R5 schedule k=%0d", k),
          {26'd0, phi1, phi2, r1, f1, r2, f2}, {26'd0, sched(k, PL, GL)});
      chk($sformatf("R1 exclusive k=%0d", k), {31'd0, phi1 & phi2}, 32'd0);
      chk($sformatf("R5 short schedule k=%0d", k),
          {26'd0, s_phi1, s_phi2, s_r1, s_f1, s_r2, s_f2}, {26'd0, sched(k, PS, GS)});
    end
  endtask

  task automatic t_load();
    bus = {8'hC3, 8'h5A, 8'h11};
    en = 3'b001;
    @(negedge clk);
    chk("R6 load driver0", {24'd0, bo}, 32'h11);
    en = 3'b100;
    @(negedge clk);
    chk("R6 load driver2", {24'd0, bo}, 32'hC3);
    chk("R8 no contention yet", {31'd0, cont}, 32'd0);
  endtask

  task automatic t_hold();
    en = '0;
    bus = {8'hFF, 8'hEE, 8'hDD};
    repeat (5) begin
      @(negedge clk);
      chk("R7 hold while idle", {24'd0, bo}, 32'hC3);
    end
  endtask

  task automatic t_contention();
    en = 3'b011;
    @(negedge clk);
    chk("R8 value kept on contention", {24'd0, bo}, 32'hC3);
    chk("R8 flag raised", {31'd0, cont}, 32'd1);
    en = '0;
    repeat (3) @(negedge clk);
    chk("R8 flag sticky", {31'd0, cont}, 32'd1);
    bus = {8'h00, 8'h5A, 8'h00};
    en = 3'b010;
    @(negedge clk);
    chk("R8 load after contention", {24'd0, bo}, 32'h5A);
    chk("R8 flag still set", {31'd0, cont}, 32'd1);
    en = '0;
  endtask

  task automatic t_rereset();
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk("R9 bus cleared", {24'd0, bo}, 32'd0);
    chk("R9 contention cleared", {31'd0, cont}, 32'd0);
    chk("R3 phases cleared", {26'd0, phi1, phi2, r1, f1, r2, f2}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_phases();
    t_load();
    t_hold();
    t_contention();
    t_rereset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule